// File: doc/BRIEF.md
# Dual-CPU failover arbiter

This block chooses which of two identical controllers in a redundant safety controller is allowed to run. Each controller drives an active-high fault line and a periodic heartbeat, and each receives its own enable. A manual preference switch names the controller that starts as the working one. When that controller reports a fault, or its failure is inferred from a missing heartbeat or from the interface-module status, the enable moves to the other controller. When both have failed, no controller is enabled.

A lost heartbeat from the working controller is classified before the alarm is raised. If every redundant link to it is also down, the cause is taken to be power loss. If some link is still up and its interface module still answers, the cause is taken to be a controller fault. If some link is up but its interface module is silent, or the partner's interface module flags a problem with it at any time, the cause is an interface-module fault. Each class lights a sticky fault indicator and the alarm. The takeover is latched: control never moves back to the first controller by itself. Only a reset or a clear pulse restarts the selection.

Top module: `failover_arbiter`

## Requirements
- R1: After reset, or on the cycle after a one-cycle clear pulse, both enables, all indicators and the alarm are low. On the next clock edge the preferred controller is enabled if its fault line is low: controller A when prefer_a_i is 1, and controller B when it is 0.
- R2: When the preferred controller's fault line is high at selection time, the other controller is enabled if its fault line is low. If both fault lines are high, neither controller is enabled.
- R3: While a controller is enabled and no takeover has happened since reset or clear, a high level on its fault line moves the enable to the other controller on the next clock edge, provided the other controller's fault line is low. A fault line alone lights no indicator and does not raise the alarm.
- R4: Whenever both fault lines are high, both enables are low from the next clock edge on.
- R5: The enables are registered and are never both high.
- R6: A heartbeat counts as lost when the enabled controller's heartbeat input has no rising edge for TIMEOUT clock cycles. A controller whose heartbeat rises at least every 6 cycles is never treated as failed.
- R7: A lost heartbeat while all link_ok_i bits are 0 sets indicator bit 0 (power loss), raises the alarm and hands over to the other controller.
- R8: A lost heartbeat while some link_ok_i bit is 1 and ifm_alive_i is 1 sets indicator bit 1 (controller fault), raises the alarm and hands over to the other controller.
- R9: A high ifm_flag_i while a controller is enabled, or a lost heartbeat while some link is up and ifm_alive_i is 0, sets indicator bit 2 (interface-module fault), raises the alarm and hands the enable to the other controller.
- R10: After a takeover, the enable stays with the replacement even after the first controller recovers. A later failure of the replacement disables both controllers.
- R11: A clear pulse drops the indicators, the alarm and the latched takeover, and restarts the selection of R1 and R2.
- R12: Indicators and the alarm stay set until reset or clear. A fault on the controller that is not enabled leaves the enabled controller and the indicators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prefer_a_i | input | 1 | Manual switch: 1 starts controller A, 0 starts controller B |
| flt_a_i | input | 1 | Fault status of controller A, active high |
| flt_b_i | input | 1 | Fault status of controller B, active high |
| hb_a_i | input | 1 | Heartbeat from controller A; rising edges count |
| hb_b_i | input | 1 | Heartbeat from controller B; rising edges count |
| link_ok_i | input | NLINK | Status of each redundant link to the enabled controller, 1 = up |
| ifm_alive_i | input | 1 | Interface module of the enabled controller still answers |
| ifm_flag_i | input | 1 | Partner interface module reports a problem with the enabled one |
| clear_i | input | 1 | One-cycle pulse that restarts selection and clears indicators |
| en_a_o | output | 1 | Enable for controller A |
| en_b_o | output | 1 | Enable for controller B |
| fault_ind_o | output | 3 | Sticky indicators: bit 0 power loss, bit 1 controller, bit 2 interface |
| alarm_o | output | 1 | Sticky alarm, set together with any indicator |

## Verification
Assertions check on every cycle that the enables are never both high, that both fault lines together disable both controllers, and that a fault on the working controller hands over while no takeover has happened. They also check that a latched takeover never returns control, that the alarm is sticky, that a power-loss indicator appears only after all links were down, and that a heartbeat edge clears the timeout. Only the bench scenarios show which indicator goes with which combination of link and interface status. The same holds for the exact start-up choice under each switch setting, for the absence of a switch-back after recovery, and for the restart after a clear.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_RUN_A = 2'd1,
    ST_RUN_B = 2'd2,
    ST_HALT  = 2'd3
  } sel_state_e;

  localparam int IND_W    = 3;
  localparam int IND_PWR  = 0;
  localparam int IND_CTRL = 1;
  localparam int IND_IFC  = 2;
endpackage

// File: rtl/fa_hb_monitor.sv
module fa_hb_monitor #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hb_i,
  output logic timeout_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic          hb_d;
  logic [CW-1:0] cnt_q;
  logic          edge_w;

  assign edge_w = hb_i & ~hb_d;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hb_d  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hb_d <= hb_i;
      if (edge_w)
        cnt_q <= '0;
      else if (cnt_q != LIMIT)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = (cnt_q == LIMIT);

  AST_HB_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (edge_w && !clr) |=> !timeout_o); // R6
endmodule

// File: rtl/fa_fault_classifier.sv
module fa_fault_classifier
  import fa_pkg::*;
#(
  parameter int NLINK = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             active_b,
  input  logic             to_a,
  input  logic             to_b,
  input  logic [NLINK-1:0] link_ok,
  input  logic             ifm_alive,
  input  logic             ifm_flag,
  output logic             act_event_o,
  output logic [IND_W-1:0] ind_o,
  output logic             alarm_o
);
  logic             hb_lost;
  logic             any_link;
  logic [IND_W-1:0] ev;

  assign hb_lost  = run & (active_b ? to_b : to_a);
  assign any_link = |link_ok;

  always_comb begin
    ev           = '0;
    ev[IND_PWR]  = hb_lost & ~any_link;
    ev[IND_CTRL] = hb_lost & any_link & ifm_alive;
    ev[IND_IFC]  = (hb_lost & any_link & ~ifm_alive) | (run & ifm_flag);
  end

  assign act_event_o = |ev;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ind_o   <= '0;
      alarm_o <= 1'b0;
    end else begin
      ind_o   <= ind_o | ev;
      alarm_o <= alarm_o | (|ev);
    end
  end

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm_o && !clr) |=> alarm_o); // R12
  AST_PWR_NEEDS_LINKS_DOWN: assert property (@(posedge clk) disable iff (rst)
    $rose(ind_o[IND_PWR]) |-> $past(link_ok == '0)); // R7
  AST_IND_NEEDS_ALARM: assert property (@(posedge clk) disable iff (rst)
    (ind_o != '0) |-> alarm_o); // R12
endmodule

// File: rtl/fa_select_fsm.sv
module fa_select_fsm
  import fa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic prefer_a,
  input  logic flt_a,
  input  logic flt_b,
  input  logic act_fail,
  output logic run_o,
  output logic active_b_o,
  output logic en_a_o,
  output logic en_b_o
);
  sel_state_e state_q, nxt;
  logic       sw_q, nxt_sw;

  always_comb begin
    nxt    = state_q;
    nxt_sw = sw_q;
    case (state_q)
      ST_INIT: begin
        if (prefer_a) begin
          if (!flt_a)      nxt = ST_RUN_A;
          else if (!flt_b) nxt = ST_RUN_B;
          else             nxt = ST_HALT;
        end else begin
          if (!flt_b)      nxt = ST_RUN_B;
          else if (!flt_a) nxt = ST_RUN_A;
          else             nxt = ST_HALT;
        end
      end
      ST_RUN_A: begin
        if (flt_a || act_fail) begin
          if (!flt_b && !sw_q) begin
            nxt    = ST_RUN_B;
            nxt_sw = 1'b1;
          end else begin
            nxt = ST_HALT;
          end
        end
      end
      ST_RUN_B: begin
        if (flt_b || act_fail) begin
          if (!flt_a && !sw_q) begin
            nxt    = ST_RUN_A;
            nxt_sw = 1'b1;
          end else begin
            nxt = ST_HALT;
          end
        end
      end
      default: nxt = ST_HALT;
    endcase
    if (clr) begin
      nxt    = ST_INIT;
      nxt_sw = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      sw_q    <= 1'b0;
      en_a_o  <= 1'b0;
      en_b_o  <= 1'b0;
    end else begin
      state_q <= nxt;
      sw_q    <= nxt_sw;
      en_a_o  <= (nxt == ST_RUN_A);
      en_b_o  <= (nxt == ST_RUN_B);
    end
  end

  assign run_o      = (state_q == ST_RUN_A) || (state_q == ST_RUN_B);
  assign active_b_o = (state_q == ST_RUN_B);

  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(en_a_o && en_b_o)); // R5
  AST_BOTH_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
    (flt_a && flt_b) |=> (!en_a_o && !en_b_o)); // R4
  AST_TAKEOVER_A: assert property (@(posedge clk) disable iff (rst)
    (en_a_o && !sw_q && flt_a && !flt_b && !clr) |=> en_b_o); // R3
  AST_TAKEOVER_B: assert property (@(posedge clk) disable iff (rst)
    (en_b_o && !sw_q && flt_b && !flt_a && !clr) |=> en_a_o); // R3
  AST_SWITCH_LATCHED_A: assert property (@(posedge clk) disable iff (rst)
    (en_a_o && sw_q && !clr) |=> !en_b_o); // R10
  AST_SWITCH_LATCHED_B: assert property (@(posedge clk) disable iff (rst)
    (en_b_o && sw_q && !clr) |=> !en_a_o); // R10
endmodule

// File: rtl/failover_arbiter.sv
module failover_arbiter
  import fa_pkg::*;
#(
  parameter int TIMEOUT = 16,
  parameter int NLINK   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prefer_a_i,
  input  logic             flt_a_i,
  input  logic             flt_b_i,
  input  logic             hb_a_i,
  input  logic             hb_b_i,
  input  logic [NLINK-1:0] link_ok_i,
  input  logic             ifm_alive_i,
  input  logic             ifm_flag_i,
  input  logic             clear_i,
  output logic             en_a_o,
  output logic             en_b_o,
  output logic [IND_W-1:0] fault_ind_o,
  output logic             alarm_o
);
  localparam int NCPU = 2;

  logic [NCPU-1:0] hb_vec;
  logic [NCPU-1:0] to_vec;
  logic            run_w, active_b_w, act_event_w;

  assign hb_vec = {hb_b_i, hb_a_i};

  for (genvar g = 0; g < NCPU; g++) begin : g_mon
    fa_hb_monitor #(.TIMEOUT(TIMEOUT)) mon_i (
      .clk       (clk),
      .rst       (rst),
      .clr       (clear_i),
      .hb_i      (hb_vec[g]),
      .timeout_o (to_vec[g])
    );
  end

  fa_fault_classifier #(.NLINK(NLINK)) cls_i (
    .clk         (clk),
    .rst         (rst),
    .clr         (clear_i),
    .run         (run_w),
    .active_b    (active_b_w),
    .to_a        (to_vec[0]),
    .to_b        (to_vec[1]),
    .link_ok     (link_ok_i),
    .ifm_alive   (ifm_alive_i),
    .ifm_flag    (ifm_flag_i),
    .act_event_o (act_event_w),
    .ind_o       (fault_ind_o),
    .alarm_o     (alarm_o)
  );

  fa_select_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .clr        (clear_i),
    .prefer_a   (prefer_a_i),
    .flt_a      (flt_a_i),
    .flt_b      (flt_b_i),
    .act_fail   (act_event_w),
    .run_o      (run_w),
    .active_b_o (active_b_w),
    .en_a_o     (en_a_o),
    .en_b_o     (en_b_o)
  );
endmodule

// File: tb/failover_arbiter_tb_top.sv
module failover_arbiter_tb_top;
  localparam int TO = 16;
  localparam int NL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prefer_a = 1'b1, flt_a = 1'b0, flt_b = 1'b0;
  logic hb_a = 1'b0, hb_b = 1'b0;
  logic hb_run_a = 1'b1, hb_run_b = 1'b1;
  logic [NL-1:0] link_ok = '1;
  logic ifm_alive = 1'b1, ifm_flag = 1'b0, clear = 1'b0;
  logic en_a, en_b, alarm;
  logic [2:0] ind;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  failover_arbiter #(.TIMEOUT(TO), .NLINK(NL)) dut_i (
    .clk(clk), .rst(rst), .prefer_a_i(prefer_a), .flt_a_i(flt_a), .flt_b_i(flt_b),
    .hb_a_i(hb_a), .hb_b_i(hb_b), .link_ok_i(link_ok), .ifm_alive_i(ifm_alive),
    .ifm_flag_i(ifm_flag), .clear_i(clear), .en_a_o(en_a), .en_b_o(en_b),
    .fault_ind_o(ind), .alarm_o(alarm)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (hb_run_a) hb_a = ~hb_a;
      if (hb_run_b) hb_b = ~hb_b;
    end
  end

  function automatic logic [5:0] expv(bit ea, bit eb, logic [2:0] iv);
    return {ea, eb, iv, |iv};
  endfunction

  function automatic logic [2:0] classify(logic [NL-1:0] lk, bit alive);
    if (lk == '0) return 3'b001;
    if (alive)    return 3'b010;
    return 3'b100;
  endfunction

  function automatic logic [1:0] start_sel(bit pa, bit fa, bit fb);
    if (pa) return !fa ? 2'b10 : (!fb ? 2'b01 : 2'b00);
    return !fb ? 2'b01 : (!fa ? 2'b10 : 2'b00);
  endfunction

  task automatic chk(string req, logic [5:0] exp);
    logic [5:0] act;
    act = {en_a, en_b, ind, alarm};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {en_a,en_b,ind,alarm} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet;
    flt_a = 0; flt_b = 0; hb_run_a = 1; hb_run_b = 1;
    link_ok = '1; ifm_alive = 1; ifm_flag = 0;
    waitn(2);
  endtask

  task automatic do_clear;
    clear = 1; waitn(1); clear = 0; waitn(1);
  endtask

  task automatic set_flt(bit on_a, logic v);
    if (on_a) flt_a = v; else flt_b = v;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit pa;
    int kind;
    logic [2:0] cls;
    logic [1:0] s;
    void'($urandom(32'd4242));

    waitn(3);
    chk("R1 during reset", 6'b0);
    rst = 0;
    waitn(1);
    chk("R1 after reset pref A", expv(1, 0, 3'b000));

    prefer_a = 0; clear = 1; waitn(1);
    chk("R11 clear cycle", 6'b0);
    clear = 0; waitn(1);
    chk("R1 pref B", expv(0, 1, 3'b000));

    prefer_a = 1; flt_a = 1; do_clear();
    chk("R2 preferred A faulted", expv(0, 1, 3'b000));
    flt_b = 1; waitn(1);
    chk("R4 both faults while running", expv(0, 0, 3'b000));
    do_clear();
    chk("R2 both faulted at start", expv(0, 0, 3'b000));
    quiet(); do_clear();
    chk("R11 restart after halt", expv(1, 0, 3'b000));

    ifm_flag = 1; waitn(1); ifm_flag = 0;
    chk("R9 flag takeover", expv(0, 1, 3'b100));
    do_clear();
    chk("R11 clears indicators", expv(1, 0, 3'b000));

    for (int ep = 0; ep < 40; ep++) begin
      quiet();
      pa = 1'($urandom % 2);
      prefer_a = pa;
      do_clear();
      s = start_sel(pa, 0, 0);
      chk("R1 random start", expv(s[1], s[0], 3'b000));
      kind = $urandom % 4;
      cls = 3'b000;
      case (kind)
        0: begin
          set_flt(pa, 1); waitn(1);
          chk("R3 fault line takeover", expv(!pa, pa, 3'b000));
          waitn(2);
          set_flt(pa, 0);
        end
        1: begin
          link_ok = ($urandom % 3 == 0) ? '0 : NL'($urandom);
          ifm_alive = 1'($urandom % 2);
          cls = classify(link_ok, ifm_alive);
          if (pa) hb_run_a = 0; else hb_run_b = 0;
          waitn(6);
          chk("R6 no early timeout", expv(pa, !pa, 3'b000));
          waitn(TO + 8);
          if (cls == 3'b001)      chk("R7 power loss", expv(!pa, pa, cls));
          else if (cls == 3'b010) chk("R8 controller fault", expv(!pa, pa, cls));
          else                    chk("R9 interface fault", expv(!pa, pa, cls));
        end
        2: begin
          cls = 3'b100;
          ifm_flag = 1; waitn(1); ifm_flag = 0;
          chk("R9 interface flag", expv(!pa, pa, cls));
        end
        default: begin
          set_flt(!pa, 1); waitn(4);
          chk("R12 standby fault ignored", expv(pa, !pa, 3'b000));
          set_flt(!pa, 0);
        end
      endcase
      if (kind != 3) begin
        flt_a = 0; flt_b = 0; hb_run_a = 1; hb_run_b = 1;
        link_ok = '1; ifm_alive = 1;
        waitn(TO + 8);
        chk("R10 no switch back", expv(!pa, pa, cls));
        set_flt(!pa, 1); waitn(1);
        chk("R10 replacement failure halts", expv(0, 0, cls));
        chk("R12 indicators sticky", expv(0, 0, cls));
        set_flt(!pa, 0);
      end
    end

    summary();
  end
endmodule